// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit device virtual address into a physical address. It reads a two-level table of 4 KiB pages from memory. A caller offers an address and a direction flag (read or write) over a valid/ready handshake. The walker then fetches at most two 32-bit entries through a simple memory read port. It returns one response: either the physical address, or a fault code together with the untranslated address and the direction flag.

The directory base is sampled when a request is accepted. It must be a plain byte address. The walker handles one walk at a time, so a request is not taken until the previous response has been handed over. A response stays on the outputs until the consumer accepts it. A memory fetch holds its address until the memory acknowledges it. The acknowledge carries the entry data and an error flag.

Top module: `pt_walker`

## Requirements
- R1: The first fetch reads address dir_base + 4*va[31:22]. The second fetch reads address tbl + 4*va[21:12], where tbl is the first entry with only bit 0 forced to zero.
- R2: If the first entry has bit 0 (present) clear, the walk ends after that single fetch with fault code 1.
- R3: If the second entry has bit 0 clear, the walk ends with fault code 2.
- R4: In the second entry, bit 1 allows reads and bit 2 allows writes. An access whose bit is clear ends with fault code 3.
- R5: A successful walk gives fault code 0 and a physical address of {second entry[31:12], va[11:0]}. Entry bits 3 to 11 have no influence on the result.
- R6: An error on either fetch ends the walk with fault code 4, and no further fetch is issued.
- R7: Every response echoes the input address and the direction flag (1 = write). A fault response drives the physical address as zero.
- R8: The request ready output is high only while idle. It stays low from acceptance until the response handshake.
- R9: While a response is valid but not accepted, all response outputs stay unchanged.
- R10: A memory read request stays asserted, with a stable address, until it is acknowledged.
- R11: After reset the block is idle: request ready high, response valid low, no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dir_base | input | 32 | Directory base address, sampled on request acceptance |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_addr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_req | output | 1 | Entry fetch requested |
| mem_addr | output | 32 | Byte address of the entry to fetch |
| mem_ack | input | 1 | Fetch complete, data and error valid this cycle |
| mem_data | input | 32 | Fetched entry |
| mem_err | input | 1 | Fetch ended with an error |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pa | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 3 | 0 ok, 1 first level absent, 2 second level absent, 3 permission, 4 bus error |
| rsp_fault_addr | output | 32 | Untranslated input address |
| rsp_fault_write | output | 1 | Direction flag of the access |

## Verification
The assertions assume a well-behaved memory. It raises mem_ack only while mem_req is high, for a single cycle per fetch, and mem_data and mem_err are meaningful only in that cycle. The bench memory model follows this rule. It answers only pending requests, adds a latency of zero to two cycles, and drops the acknowledge after one cycle. It keeps rsp_ready low for a varying number of cycles so that the hold-stable checks are exercised. It returns all ones on erroring fetches, so an error has to win over a present bit.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int PRESENT_BIT = 0;
  localparam int RD_OK_BIT   = 1;
  localparam int WR_OK_BIT   = 2;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_L1_ABSENT = 3'd1,
    FLT_L2_ABSENT = 3'd2,
    FLT_PERM      = 3'd3,
    FLT_BUS       = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_TBL  = 2'd2,
    ST_HOLD = 2'd3
  } walk_state_e;

endpackage

// File: rtl/ptw_fetch_addr.sv
module ptw_fetch_addr #(
  parameter int AW    = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic [AW-1:0]              dir_base,
  input  logic [AW-1:0]              tbl_base,
  input  logic [2*IDX_W+OFF_W-1:0]   va,
  input  logic                       second,
  output logic [AW-1:0]              fetch_addr
);
  localparam int VA_W      = 2*IDX_W + OFF_W;
  localparam int ENT_LOG2  = 2;
  localparam int PAD_W     = AW - IDX_W - ENT_LOG2;

  logic [IDX_W-1:0] dir_idx;
  logic [IDX_W-1:0] tbl_idx;
  logic [IDX_W-1:0] use_idx;
  logic [AW-1:0]    use_base;
  logic [AW-1:0]    byte_off;

  always_comb begin
    dir_idx    = va[VA_W-1 -: IDX_W];
    tbl_idx    = va[OFF_W +: IDX_W];
    use_idx    = second ? tbl_idx : dir_idx;
    use_base   = second ? tbl_base : dir_base;
    byte_off   = {{PAD_W{1'b0}}, use_idx, {ENT_LOG2{1'b0}}};
    fetch_addr = use_base + byte_off;
  end

endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
  import ptw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFF_W = 12
) (
  input  logic [AW-1:0]    entry,
  input  logic [OFF_W-1:0] page_off,
  input  logic             is_write,
  output logic             present,
  output logic             allowed,
  output logic [AW-1:0]    next_base,
  output logic [AW-1:0]    phys
);

  always_comb begin
    present   = entry[PRESENT_BIT];
    allowed   = is_write ? entry[WR_OK_BIT] : entry[RD_OK_BIT];
    next_base = {entry[AW-1:1], 1'b0};
    phys      = {entry[AW-1:OFF_W], page_off};
  end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            dir_base,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [2*IDX_W+OFF_W-1:0] req_addr,
  input  logic                     req_write,
  output logic                     mem_req,
  output logic [AW-1:0]            mem_addr,
  input  logic                     mem_ack,
  input  logic [AW-1:0]            mem_data,
  input  logic                     mem_err,
  input  logic                     rsp_fire,
  output logic                     done,
  output fault_e                   done_fault,
  output logic [AW-1:0]            done_pa,
  output logic [2*IDX_W+OFF_W-1:0] cur_va,
  output logic                     cur_write
);
  localparam int VA_W = 2*IDX_W + OFF_W;

  walk_state_e      state_q, state_d;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [AW-1:0]    dir_q;
  logic [AW-1:0]    tbl_q, tbl_d;
  logic             cap_en;
  logic             tbl_en;

  logic             ent_present;
  logic             ent_allowed;
  logic [AW-1:0]    ent_next;
  logic [AW-1:0]    ent_phys;

  ptw_fetch_addr #(.AW(AW), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .dir_base   (dir_q),
    .tbl_base   (tbl_q),
    .va         (va_q),
    .second     (state_q == ST_TBL),
    .fetch_addr (mem_addr)
  );

  ptw_entry_decode #(.AW(AW), .OFF_W(OFF_W)) u_dec (
    .entry     (mem_data),
    .page_off  (va_q[OFF_W-1:0]),
    .is_write  (wr_q),
    .present   (ent_present),
    .allowed   (ent_allowed),
    .next_base (ent_next),
    .phys      (ent_phys)
  );

  always_comb begin
    state_d    = state_q;
    tbl_d      = tbl_q;
    cap_en     = 1'b0;
    tbl_en     = 1'b0;
    done       = 1'b0;
    done_fault = FLT_NONE;
    done_pa    = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          state_d = ST_DIR;
        end
      end
      ST_DIR: begin
        if (mem_ack) begin
          if (mem_err) begin
            done       = 1'b1;
            done_fault = FLT_BUS;
            state_d    = ST_HOLD;
          end else if (!ent_present) begin
            done       = 1'b1;
            done_fault = FLT_L1_ABSENT;
            state_d    = ST_HOLD;
          end else begin
            tbl_en  = 1'b1;
            tbl_d   = ent_next;
            state_d = ST_TBL;
          end
        end
      end
      ST_TBL: begin
        if (mem_ack) begin
          done    = 1'b1;
          state_d = ST_HOLD;
          if (mem_err) begin
            done_fault = FLT_BUS;
          end else if (!ent_present) begin
            done_fault = FLT_L2_ABSENT;
          end else if (!ent_allowed) begin
            done_fault = FLT_PERM;
          end else begin
            done_pa = ent_phys;
          end
        end
      end
      ST_HOLD: begin
        if (rsp_fire) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q  <= '0;
      wr_q  <= 1'b0;
      dir_q <= '0;
    end else if (cap_en) begin
      va_q  <= req_addr;
      wr_q  <= req_write;
      dir_q <= dir_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tbl_q <= '0;
    else if (tbl_en) tbl_q <= tbl_d;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_DIR) || (state_q == ST_TBL);
  assign cur_va    = va_q;
  assign cur_write = wr_q;

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R10

  AST_BUS_ERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> !mem_req); // R6

  AST_DIR_ABSENT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DIR) && mem_ack && !mem_err && !mem_data[PRESENT_BIT] |=> !mem_req); // R2

endmodule

// File: rtl/ptw_resp.sv
module ptw_resp
  import ptw_pkg::*;
#(
  parameter int AW   = 32,
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  fault_e          in_fault,
  input  logic [AW-1:0]   in_pa,
  input  logic [VA_W-1:0] in_va,
  input  logic            in_write,
  input  logic            rsp_ready,
  output logic            rsp_valid,
  output logic [AW-1:0]   rsp_pa,
  output fault_e          rsp_fault,
  output logic [VA_W-1:0] rsp_va,
  output logic            rsp_write
);

  logic            valid_q, valid_d;
  logic [AW-1:0]   pa_q;
  fault_e          fault_q;
  logic [VA_W-1:0] va_q;
  logic            wr_q;

  always_comb begin
    valid_d = valid_q;
    if (load)                      valid_d = 1'b1;
    else if (valid_q && rsp_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q    <= '0;
      fault_q <= FLT_NONE;
      va_q    <= '0;
      wr_q    <= 1'b0;
    end else if (load) begin
      pa_q    <= in_pa;
      fault_q <= in_fault;
      va_q    <= in_va;
      wr_q    <= in_write;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_pa    = pa_q;
  assign rsp_fault = fault_q;
  assign rsp_va    = va_q;
  assign rsp_write = wr_q;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable({rsp_pa, rsp_fault, rsp_va, rsp_write})); // R9

  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault != FLT_NONE) |-> (rsp_pa == '0)); // R7

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   dir_base,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [31:0]   req_addr,
  input  logic          req_write,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_data,
  input  logic          mem_err,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [31:0]   rsp_pa,
  output logic [2:0]    rsp_fault,
  output logic [31:0]   rsp_fault_addr,
  output logic          rsp_fault_write
);
  localparam int VA_W = 2*IDX_W + OFF_W;

  logic [1:0]      rst_pipe_q;
  logic            arst_n;
  logic            done;
  fault_e          done_fault;
  logic [AW-1:0]   done_pa;
  logic [VA_W-1:0] cur_va;
  logic            cur_write;
  fault_e          fault_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign arst_n = rst_pipe_q[1];

  ptw_ctrl #(.AW(AW), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (arst_n),
    .dir_base   (dir_base),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_data   (mem_data),
    .mem_err    (mem_err),
    .rsp_fire   (rsp_valid && rsp_ready),
    .done       (done),
    .done_fault (done_fault),
    .done_pa    (done_pa),
    .cur_va     (cur_va),
    .cur_write  (cur_write)
  );

  ptw_resp #(.AW(AW), .VA_W(VA_W)) u_resp (
    .clk       (clk),
    .rst_n     (arst_n),
    .load      (done),
    .in_fault  (done_fault),
    .in_pa     (done_pa),
    .in_va     (cur_va),
    .in_write  (cur_write),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_pa    (rsp_pa),
    .rsp_fault (fault_out),
    .rsp_va    (rsp_fault_addr),
    .rsp_write (rsp_fault_write)
  );

  assign rsp_fault = fault_out;

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!arst_n)
    (rsp_valid || mem_req) |-> !req_ready); // R8

  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!arst_n)
    req_valid && req_ready |=> !req_ready); // R8

endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam logic [31:0] DIR = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dir_base = DIR;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_data = '0;
  logic        mem_err = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_pa;
  logic [2:0]  rsp_fault;
  logic [31:0] rsp_fault_addr;
  logic        rsp_fault_write;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data), .mem_err(mem_err),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .rsp_fault_addr(rsp_fault_addr), .rsp_fault_write(rsp_fault_write)
  );

  typedef struct {
    logic [31:0] va;
    logic        wr;
    logic [31:0] pa;
    logic [2:0]  flt;
    int          fetches;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] mem_img [logic [31:0]];
  bit          err_img [logic [31:0]];
  int          nchk = 0;
  int          nerr = 0;
  int          fetch_cnt = 0;
  int          fetch_base = 0;
  bit          running = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    if (err_img.exists(a)) return 32'hFFFF_FFFF;
    if (mem_img.exists(a)) return mem_img[a];
    return 32'h0;
  endfunction

  // memory model: 0..2 cycles latency, one-cycle acknowledge, address held (R10)
  bit          pend = 1'b0;
  logic [31:0] pend_addr = '0;
  int          wait_n = 0;
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req) begin
      if (!pend) begin
        pend = 1'b1;
        pend_addr = mem_addr;
        wait_n = fetch_cnt % 3;
      end else begin
        check(mem_addr == pend_addr, "R10", "fetch address moved", mem_addr, pend_addr);
      end
      if (wait_n == 0) begin
        mem_ack  = 1'b1;
        mem_data = rd_word(pend_addr);
        mem_err  = err_img.exists(pend_addr);
        fetch_cnt++;
        pend = 1'b0;
      end else begin
        wait_n--;
      end
    end
  end

  // monitor / scoreboard
  bit          seen = 1'b0;
  int          stall = 0;
  int          ntx = 0;
  logic [31:0] snap_pa, snap_va;
  logic [2:0]  snap_f;
  logic        snap_w;
  always @(negedge clk) begin
    if (running) begin
      if (rsp_valid) begin
        check(req_ready == 1'b0, "R8", "ready while response pending", {31'b0, req_ready}, 32'h0);
        if (!seen) begin
          seen = 1'b1;
          snap_pa = rsp_pa; snap_va = rsp_fault_addr; snap_f = rsp_fault; snap_w = rsp_fault_write;
          stall = ntx % 3;
        end else begin
          check(rsp_pa == snap_pa && rsp_fault_addr == snap_va && rsp_fault == snap_f &&
                rsp_fault_write == snap_w, "R9", "response changed while stalled", rsp_pa, snap_pa);
        end
        if (stall > 0) begin
          stall--;
          rsp_ready = 1'b0;
        end else if (sb_q.size() == 0) begin
          check(1'b0, "R8", "unexpected response", rsp_fault_addr, 32'h0);
          rsp_ready = 1'b1;
          seen = 1'b0;
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(rsp_fault == e.flt, e.tag, "fault code", {29'b0, rsp_fault}, {29'b0, e.flt});
          check(rsp_pa == e.pa, e.tag, "physical address", rsp_pa, e.pa);
          check(rsp_fault_addr == e.va, "R7", "echoed address", rsp_fault_addr, e.va);
          check(rsp_fault_write == e.wr, "R7", "echoed direction", {31'b0, rsp_fault_write}, {31'b0, e.wr});
          check((fetch_cnt - fetch_base) == e.fetches, e.tag, "fetch count",
                fetch_cnt - fetch_base, e.fetches);
          fetch_base = fetch_cnt;
          ntx++;
          rsp_ready = 1'b1;
          seen = 1'b0;
        end
      end else begin
        rsp_ready = 1'b0;
      end
    end
  end

  task automatic send(input logic [31:0] va, input logic wr, input logic [31:0] pa,
                      input logic [2:0] flt, input int nf, input string tag);
    exp_t e;
    e.va = va; e.wr = wr; e.pa = pa; e.flt = flt; e.fetches = nf; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = va;
    req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = 32'hDEAD_BEEF;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired, %0d responses outstanding", sb_q.size());
    summary();
    $finish;
  end

  initial begin
    mem_img[DIR + 32'h000] = 32'h00B0_0001;
    mem_img[32'h00B0_0000] = 32'h1000_0003;
    mem_img[DIR + 32'h004] = 32'h0020_0001;
    mem_img[32'h0020_0004] = 32'h0ABC_D007;
    mem_img[32'h0020_0008] = 32'h0555_5006;
    mem_img[32'h0020_000C] = 32'h0666_6003;
    mem_img[32'h0020_0010] = 32'h0777_7005;
    mem_img[32'h0020_0018] = 32'h0888_8001;
    mem_img[DIR + 32'h008] = 32'h0030_0003;
    mem_img[32'h0030_0016] = 32'h1234_5FFF;
    mem_img[DIR + 32'h010] = 32'h0040_0000;
    err_img[DIR + 32'h014] = 1'b1;
    mem_img[DIR + 32'h018] = 32'h0090_0001;
    err_img[32'h0090_001C] = 1'b1;
    mem_img[DIR + 32'hFFC] = 32'h00A0_0001;
    mem_img[32'h00A0_0FFC] = 32'hFEDC_B007;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 idle after reset
    check(req_ready == 1'b1, "R11", "req_ready after reset", {31'b0, req_ready}, 32'h1);
    check(rsp_valid == 1'b0, "R11", "rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    check(mem_req == 1'b0,   "R11", "mem_req after reset", {31'b0, mem_req}, 32'h0);
    running = 1'b1;

    send(32'h0000_0000, 1'b0, 32'h1000_0000, 3'd0, 2, "R1");
    send(32'h0040_1234, 1'b0, 32'h0ABC_D234, 3'd0, 2, "R5");
    send(32'h0040_1234, 1'b1, 32'h0ABC_D234, 3'd0, 2, "R5");
    send(32'h0080_5ABC, 1'b1, 32'h1234_5ABC, 3'd0, 2, "R1");
    send(32'h00C0_0000, 1'b0, 32'h0,         3'd1, 1, "R2");
    send(32'h0100_0000, 1'b1, 32'h0,         3'd1, 1, "R2");
    send(32'h0040_2010, 1'b0, 32'h0,         3'd2, 2, "R3");
    send(32'h0040_3FFF, 1'b0, 32'h0666_6FFF, 3'd0, 2, "R4");
    send(32'h0040_3FFF, 1'b1, 32'h0,         3'd3, 2, "R4");
    send(32'h0040_4000, 1'b0, 32'h0,         3'd3, 2, "R4");
    send(32'h0040_4000, 1'b1, 32'h0777_7000, 3'd0, 2, "R4");
    send(32'h0040_6008, 1'b0, 32'h0,         3'd3, 2, "R4");
    send(32'h0040_6008, 1'b1, 32'h0,         3'd3, 2, "R4");
    send(32'h0140_0000, 1'b0, 32'h0,         3'd4, 1, "R6");
    send(32'h0180_7000, 1'b1, 32'h0,         3'd4, 2, "R6");
    send(32'hFFFF_FFFF, 1'b1, 32'hFEDC_BFFF, 3'd0, 2, "R5");

    while (sb_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check(req_ready == 1'b1, "R8", "ready after last handshake", {31'b0, req_ready}, 32'h1);
    summary();
    $finish;
  end

endmodule